// File: doc/BRIEF.md
# Multithreaded Retire Thread Picker

This block sits in the retire stage of a core that runs several hardware threads. Each thread keeps its own reorder buffer. For every retire slot, the picker decides which thread may retire the instruction at the head of its buffer. It reads a status code, a head-ready flag, an empty flag and the sequence number of the head instruction for every thread. From these it drives a thread index and a valid bit. When the valid bit is low, no thread may retire in that slot.

A two-bit configuration input chooses the arbitration policy.

- **Rotating policy.** This policy walks a registered priority list. The thread it picks drops to the tail of the list on the next clock edge.
- **Age-based policies.** These pick the ready thread whose head instruction is oldest.

When the block is built for a single thread, it skips arbitration altogether. It grants that thread whenever the thread's status allows retirement.

The retirement itself and the tracking of each thread's status belong to neighbouring logic.

Top module: `commit_thread_sel`

## Requirements
- R1: The policy input is decoded as follows. 2'b00 is the greedy policy, 2'b01 is rotating, 2'b10 is oldest-first, and 2'b11 is decoded as oldest-first. The greedy policy selects exactly as oldest-first does.
- R2: Each thread's status is a 3-bit code in a flat bus, with thread t at bits [3t+2:3t]. The codes are 0 running, 1 idle, 2 flushing, 3 trap-waiting and 4 fetch-fault-pending. Codes 5 to 7 are never eligible.
- R3: Under the greedy and oldest-first policies, a thread is eligible only when all of these hold: its empty flag is 0, its status is running, idle or fetch-fault-pending, and its head-ready flag is 1.
- R4: Under the greedy and oldest-first policies, the eligible thread with the smallest head sequence number is chosen. The sequence number of thread t is at bits [SEQ_W*t+SEQ_W-1:SEQ_W*t]. On equal sequence numbers, the lower thread index wins.
- R5: Under the rotating policy, the first thread in the priority list whose status is running or idle and whose head is ready is chosen. The empty flag is not consulted.
- R6: After reset, the priority list holds the threads in ascending order, 0 first. A reset in mid-run restores this order.
- R7: A rotating-policy selection moves the chosen thread to the tail of the list at the next clock edge. The threads behind it each move one place forward and keep their relative order.
- R8: When no thread qualifies, the valid output is 0 and the thread index is 0.
- R9: With NUM_THREADS = 1, the valid output is 1 exactly when the status is running, idle or fetch-fault-pending. Ready, empty and policy have no effect, and the index is 0.
- R10: The priority list does not change in a cycle under a non-rotating policy, or in a cycle with no valid selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| policy_i | input | 2 | Arbitration policy code |
| thr_status_i | input | NUM_THREADS*3 | Per-thread status codes |
| head_ready_i | input | NUM_THREADS | Per-thread head-ready flags |
| rob_empty_i | input | NUM_THREADS | Per-thread buffer-empty flags |
| head_seq_i | input | NUM_THREADS*SEQ_W | Per-thread head sequence numbers |
| pick_valid_o | output | 1 | A thread was selected |
| pick_tid_o | output | TID_W | Selected thread index |

## Verification
The valid bit and the thread index are combinational. They follow the inputs in the same cycle. The only registered state is the priority list, so the effect of a rotating pick shows up in the selection one clock later.

The bench changes the inputs on the falling edge and samples the outputs 1 ns later. It then advances its own model of the list, which stands in for the rising edge that follows. As a result, every compare sees the list as the design holds it in that cycle. A sweep of several thousand derived input patterns, with frequent policy changes, runs alongside directed tie, empty-flag and reset cases, plus a full sweep of the single-thread build.

// File: rtl/commit_sel_pkg.sv
// Shared encodings for the retire thread picker.
// Assumes status codes come from the thread status tracker unchanged.
package commit_sel_pkg;

    typedef enum logic [1:0] {
        POL_GREEDY = 2'b00,
        POL_ROTATE = 2'b01,
        POL_OLDEST = 2'b10,
        POL_SPARE  = 2'b11
    } pol_e;

    localparam int ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        TS_RUN         = 3'd0,
        TS_IDLE        = 3'd1,
        TS_FLUSH       = 3'd2,
        TS_TRAP_WAIT   = 3'd3,
        TS_FETCH_FAULT = 3'd4
    } tstat_e;

    // Status allows a rotating-policy pick
    function automatic logic rot_status_ok(input logic [ST_W-1:0] s);
        return (s == TS_RUN) || (s == TS_IDLE);
    endfunction

    // Status allows an age-based or single-thread pick
    function automatic logic age_status_ok(input logic [ST_W-1:0] s);
        return (s == TS_RUN) || (s == TS_IDLE) || (s == TS_FETCH_FAULT);
    endfunction

endpackage

// File: rtl/thread_elig.sv
// Per-thread eligibility for the rotating and age-based policies.
// Pure combinational; one copy of the logic per thread via generate.
module thread_elig
    import commit_sel_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS*ST_W-1:0] thr_status_i,
    input  logic [NUM_THREADS-1:0]      head_ready_i,
    input  logic [NUM_THREADS-1:0]      rob_empty_i,
    output logic [NUM_THREADS-1:0]      rot_elig_o,
    output logic [NUM_THREADS-1:0]      age_elig_o
);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [ST_W-1:0] st;
        assign st = thr_status_i[t*ST_W +: ST_W];
        // Rotating policy ignores the empty flag
        assign rot_elig_o[t] = rot_status_ok(st) && head_ready_i[t];
        // Age policy also requires a non-empty buffer
        assign age_elig_o[t] = age_status_ok(st) && head_ready_i[t] && !rob_empty_i[t];
    end

endmodule

// File: rtl/oldest_pick.sv
// Picks the eligible thread with the smallest head sequence number.
// Linear scan with strict less-than, so ties keep the lower index.
module oldest_pick #(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 8,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0]       elig_i,
    input  logic [NUM_THREADS*SEQ_W-1:0] seq_i,
    output logic                         valid_o,
    output logic [TID_W-1:0]             tid_o
);

    logic [SEQ_W-1:0] best_seq;

    // Scan threads in index order keeping the oldest seen
    always_comb begin
        valid_o  = 1'b0;
        tid_o    = '0;
        best_seq = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (elig_i[t] && (!valid_o || (seq_i[t*SEQ_W +: SEQ_W] < best_seq))) begin
                valid_o  = 1'b1;
                tid_o    = TID_W'(t);
                best_seq = seq_i[t*SEQ_W +: SEQ_W];
            end
        end
    end

endmodule

// File: rtl/rr_order_list.sv
// Registered priority list for the rotating policy and its pick.
// The winner moves to the tail on advance_i; reset loads ascending order.
module rr_order_list #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] elig_i,
    input  logic                   advance_i,
    output logic                   valid_o,
    output logic [TID_W-1:0]       tid_o
);

    logic [TID_W-1:0] order_q [NUM_THREADS];
    logic [TID_W-1:0] win_pos;

    // First eligible entry walking from the head of the list
    always_comb begin
        valid_o = 1'b0;
        tid_o   = '0;
        win_pos = '0;
        for (int k = 0; k < NUM_THREADS; k++) begin
            if (!valid_o && elig_i[order_q[k]]) begin
                valid_o = 1'b1;
                tid_o   = order_q[k];
                win_pos = TID_W'(k);
            end
        end
    end

    // Load ascending order on reset, rotate the winner to the tail on advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_THREADS; k++) begin
                order_q[k] <= TID_W'(k);
            end
        end else if (advance_i) begin
            for (int k = 0; k < NUM_THREADS; k++) begin
                if (k < int'(win_pos)) begin
                    order_q[k] <= order_q[k];
                end else if (k < NUM_THREADS - 1) begin
                    order_q[k] <= order_q[(k + 1) % NUM_THREADS];
                end else begin
                    order_q[k] <= tid_o;
                end
            end
        end
    end

endmodule

// File: rtl/commit_thread_sel.sv
// Retire thread picker: selects the thread allowed to retire its head.
// Single-thread builds bypass arbitration; multi-thread builds choose
// between a rotating list and an oldest-head pick according to policy_i.
module commit_thread_sel
    import commit_sel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 8,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   policy_i,
    input  logic [NUM_THREADS*ST_W-1:0]  thr_status_i,
    input  logic [NUM_THREADS-1:0]       head_ready_i,
    input  logic [NUM_THREADS-1:0]       rob_empty_i,
    input  logic [NUM_THREADS*SEQ_W-1:0] head_seq_i,
    output logic                         pick_valid_o,
    output logic [TID_W-1:0]             pick_tid_o
);

    if (NUM_THREADS == 1) begin : g_solo
        // Single thread: grant on status alone, no readiness check
        assign pick_valid_o = age_status_ok(thr_status_i[ST_W-1:0]);
        assign pick_tid_o   = '0;
    end else begin : g_multi
        logic [NUM_THREADS-1:0] rot_elig;
        logic [NUM_THREADS-1:0] age_elig;
        logic                   rot_valid;
        logic [TID_W-1:0]       rot_tid;
        logic                   age_valid;
        logic [TID_W-1:0]       age_tid;
        logic                   use_rot;
        logic                   advance;

        thread_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
            .thr_status_i (thr_status_i),
            .head_ready_i (head_ready_i),
            .rob_empty_i  (rob_empty_i),
            .rot_elig_o   (rot_elig),
            .age_elig_o   (age_elig)
        );

        oldest_pick #(.NUM_THREADS(NUM_THREADS), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_age (
            .elig_i  (age_elig),
            .seq_i   (head_seq_i),
            .valid_o (age_valid),
            .tid_o   (age_tid)
        );

        rr_order_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_rot (
            .clk       (clk),
            .rst_n     (rst_n),
            .elig_i    (rot_elig),
            .advance_i (advance),
            .valid_o   (rot_valid),
            .tid_o     (rot_tid)
        );

        // Policy decode: only 2'b01 uses the list, all other codes age-based
        assign use_rot = (policy_i == POL_ROTATE);
        // List moves only when the rotating policy actually grants
        assign advance = use_rot && rot_valid;

        // Output mux by policy
        always_comb begin
            if (use_rot) begin
                pick_valid_o = rot_valid;
                pick_tid_o   = rot_tid;
            end else begin
                pick_valid_o = age_valid;
                pick_tid_o   = age_tid;
            end
        end
    end

endmodule

// File: rtl/commit_sel_chk.sv
// Property checker for the retire thread picker, bound to every instance.
module commit_sel_chk
    import commit_sel_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int SEQ_W       = 8,
    parameter int TID_W       = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   policy_i,
    input logic [NUM_THREADS*ST_W-1:0]  thr_status_i,
    input logic [NUM_THREADS-1:0]       head_ready_i,
    input logic [NUM_THREADS-1:0]       rob_empty_i,
    input logic [NUM_THREADS*SEQ_W-1:0] head_seq_i,
    input logic                         pick_valid_o,
    input logic [TID_W-1:0]             pick_tid_o
);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid_o |-> (pick_tid_o == '0));

    if (NUM_THREADS == 1) begin : g_solo
        // R9
        solo_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pick_valid_o |-> age_status_ok(thr_status_i[ST_W-1:0]));
        // R9
        solo_nomiss_chk: assert property (@(posedge clk) disable iff (!rst_n)
            age_status_ok(thr_status_i[ST_W-1:0]) |-> pick_valid_o);
    end else begin : g_multi
        logic [NUM_THREADS-1:0] rot_ready;
        logic [ST_W-1:0]        win_st;
        logic [SEQ_W-1:0]       win_seq;
        logic                   older_seen;

        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_rr
            assign rot_ready[t] = rot_status_ok(thr_status_i[t*ST_W +: ST_W]) && head_ready_i[t];
        end

        assign win_st  = thr_status_i[pick_tid_o*ST_W +: ST_W];
        assign win_seq = head_seq_i[pick_tid_o*SEQ_W +: SEQ_W];

        // Any qualifying thread strictly older, or equally old at a lower index
        always_comb begin
            older_seen = 1'b0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (age_status_ok(thr_status_i[t*ST_W +: ST_W]) && head_ready_i[t] &&
                    !rob_empty_i[t]) begin
                    if ((head_seq_i[t*SEQ_W +: SEQ_W] < win_seq) ||
                        ((head_seq_i[t*SEQ_W +: SEQ_W] == win_seq) && (t < int'(pick_tid_o)))) begin
                        older_seen = 1'b1;
                    end
                end
            end
        end

        // R3
        age_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_valid_o && policy_i != POL_ROTATE) |->
            (head_ready_i[pick_tid_o] && !rob_empty_i[pick_tid_o] && age_status_ok(win_st)));
        // R4
        age_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_valid_o && policy_i != POL_ROTATE) |-> !older_seen);
        // R5
        rot_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_valid_o && policy_i == POL_ROTATE) |->
            (head_ready_i[pick_tid_o] && rot_status_ok(win_st)));
        // R7
        rot_fair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_valid_o && policy_i == POL_ROTATE) ##1
            (policy_i == POL_ROTATE && $countones(rot_ready) > 1 && rot_ready[$past(pick_tid_o)])
            |-> (pick_tid_o != $past(pick_tid_o)));
    end

endmodule

bind commit_thread_sel commit_sel_chk #(
    .NUM_THREADS (NUM_THREADS),
    .SEQ_W       (SEQ_W),
    .TID_W       (TID_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .policy_i     (policy_i),
    .thr_status_i (thr_status_i),
    .head_ready_i (head_ready_i),
    .rob_empty_i  (rob_empty_i),
    .head_seq_i   (head_seq_i),
    .pick_valid_o (pick_valid_o),
    .pick_tid_o   (pick_tid_o)
);

// File: tb/sim_commit_thread_sel.sv
// Self-checking bench: four-thread build (u0) and single-thread build (u1).
module sim_commit_thread_sel;

    localparam int NT = 4;
    localparam int SW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic [1:0]      pol;
    logic [NT*3-1:0] st;
    logic [NT-1:0]   rdy;
    logic [NT-1:0]   emp;
    logic [NT*SW-1:0] seq;
    logic            vo;
    logic [1:0]      to;

    logic [1:0]      s_pol;
    logic [2:0]      s_st;
    logic [0:0]      s_rdy;
    logic [0:0]      s_emp;
    logic [SW-1:0]   s_seq;
    logic            s_vo;
    logic [0:0]      s_to;

    commit_thread_sel #(.NUM_THREADS(NT), .SEQ_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .policy_i(pol), .thr_status_i(st),
        .head_ready_i(rdy), .rob_empty_i(emp), .head_seq_i(seq),
        .pick_valid_o(vo), .pick_tid_o(to)
    );

    commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW)) u1 (
        .clk(clk), .rst_n(rst_n), .policy_i(s_pol), .thr_status_i(s_st),
        .head_ready_i(s_rdy), .rob_empty_i(s_emp), .head_seq_i(s_seq),
        .pick_valid_o(s_vo), .pick_tid_o(s_to)
    );

    int total = 0;
    int bad   = 0;
    int mlist [NT];
    bit done  = 0;
    int ev, et;
    logic [31:0] rng = 32'h1234_5678;

    function automatic bit rot_ok(int s);
        return (s == 0) || (s == 1);
    endfunction

    function automatic bit age_ok(int s);
        return (s == 0) || (s == 1) || (s == 4);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NT; k++) mlist[k] = k;
    endtask

    task automatic set_thr(int t, int s, bit r, bit e, int q);
        st[t*3 +: 3]   = 3'(s);
        rdy[t]         = r;
        emp[t]         = e;
        seq[t*SW +: SW] = SW'(q);
    endtask

    task automatic all_thr(int s, bit r, bit e, int q);
        for (int t = 0; t < NT; t++) set_thr(t, s, r, e, q);
    endtask

    // Expected pick from the requirements and the bench's own list
    task automatic expect_pick(output int v, output int tid);
        int best;
        v = 0; tid = 0; best = 0;
        if (pol == 2'b01) begin
            for (int k = 0; k < NT; k++) begin
                int t;
                t = mlist[k];
                if (v == 0 && rot_ok(int'(st[t*3 +: 3])) && rdy[t]) begin
                    v = 1; tid = t;
                end
            end
        end else begin
            for (int t = 0; t < NT; t++) begin
                if (age_ok(int'(st[t*3 +: 3])) && rdy[t] && !emp[t]) begin
                    if (v == 0 || int'(seq[t*SW +: SW]) < best) begin
                        v = 1; tid = t; best = int'(seq[t*SW +: SW]);
                    end
                end
            end
        end
    endtask

    task automatic chk(string tag, int av, int at, int xv, int xt);
        total++;
        if (av != xv || at != xt) begin
            bad++;
            $display("FAIL %s: got valid=%0d tid=%0d expected valid=%0d tid=%0d", tag, av, at, xv, xt);
        end
    endtask

    // Sample after settle, compare, then advance the model as the next edge will
    task automatic step(string tag);
        #1;
        expect_pick(ev, et);
        chk(tag, int'(vo), int'(to), ev, et);
        if (pol == 2'b01 && ev == 1 && rst_n) begin
            int p;
            p = 0;
            for (int k = 0; k < NT; k++) if (mlist[k] == et) p = k;
            for (int k = p; k < NT - 1; k++) mlist[k] = mlist[k + 1];
            mlist[NT-1] = et;
        end
    endtask

    // Watchdog ends a hung run as a failure
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pol = 2'b01;
        all_thr(2, 1, 0, 0);
        s_pol = 0; s_st = 0; s_rdy = 0; s_emp = 0; s_seq = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: nothing eligible during reset
        step("R8 reset idle");
        rst_n = 1'b1;

        // R6: ascending order after reset, then R7 rotation
        @(negedge clk); all_thr(0, 1, 0, 0); step("R6 first pick");
        chk("R6 first is thread 0", int'(vo), int'(to), 1, 0);
        @(negedge clk); step("R7 rotate 1");
        chk("R7 second is thread 1", int'(vo), int'(to), 1, 1);
        @(negedge clk); step("R7 rotate 2");
        @(negedge clk); step("R7 rotate 3");
        @(negedge clk); step("R7 wraps");
        chk("R7 wraps to thread 0", int'(vo), int'(to), 1, 0);

        // R7: middle winner goes to tail, others keep order
        @(negedge clk); all_thr(0, 0, 0, 0); set_thr(2, 1, 1, 0, 0); step("R7 middle win");
        @(negedge clk); all_thr(1, 1, 0, 0); step("R7 after middle");

        // R5: empty flag ignored, only running/idle statuses count
        @(negedge clk); all_thr(0, 1, 1, 0); step("R5 empty ignored");
        chk("R5 empty still valid", int'(vo), 0, 1, 0);
        @(negedge clk); all_thr(4, 1, 0, 0); step("R5 fetch fault not rotating");
        @(negedge clk); all_thr(3, 1, 0, 0); set_thr(3, 1, 0, 0, 0); step("R5 not ready");

        // R8: none eligible under age policy
        @(negedge clk); pol = 2'b10; all_thr(0, 1, 1, 0); step("R8 all empty");
        chk("R8 all empty invalid", int'(vo), int'(to), 0, 0);

        // R3: each eligibility condition under age policy
        @(negedge clk); all_thr(0, 1, 0, 9); set_thr(0, 4, 1, 0, 1); step("R3 fetch fault ok");
        @(negedge clk); set_thr(0, 2, 1, 0, 1); step("R3 flushing blocked");
        @(negedge clk); set_thr(0, 0, 0, 0, 1); step("R3 not ready blocked");
        @(negedge clk); set_thr(0, 0, 1, 1, 1); step("R3 empty blocked");
        @(negedge clk); set_thr(0, 7, 1, 0, 1); step("R2 code 7 blocked");

        // R4: oldest wins, ties go to the lower index
        @(negedge clk); all_thr(0, 1, 0, 5); step("R4 all tie");
        chk("R4 tie thread 0", int'(vo), int'(to), 1, 0);
        @(negedge clk); set_thr(0, 0, 1, 0, 9); set_thr(1, 0, 1, 0, 3);
        set_thr(2, 0, 1, 0, 3); set_thr(3, 0, 1, 0, 7); step("R4 tie lower");
        chk("R4 tie picks thread 1", int'(vo), int'(to), 1, 1);
        @(negedge clk); set_thr(3, 1, 1, 0, 0); step("R4 smallest");

        // R1: greedy and spare codes match oldest-first
        @(negedge clk); pol = 2'b00; step("R1 greedy");
        chk("R1 greedy picks 3", int'(vo), int'(to), 1, 3);
        @(negedge clk); pol = 2'b11; step("R1 spare code");

        // R10: list untouched by age-policy cycles
        @(negedge clk); pol = 2'b10; all_thr(0, 1, 0, 0); step("R10 age cycle a");
        @(negedge clk); step("R10 age cycle b");
        @(negedge clk); pol = 2'b01; all_thr(2, 0, 0, 0); step("R10 no grant");
        @(negedge clk); all_thr(0, 1, 0, 0); step("R10 list kept");

        // R6: mid-run reset restores ascending order
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); model_reset(); rst_n = 1'b1; step("R6 after reset");
        chk("R6 reset order thread 0", int'(vo), int'(to), 1, 0);

        // Sweep of derived patterns with frequent policy changes (R1 R3 R4 R5 R7)
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            pol = 2'((i / 6) % 4);
            for (int t = 0; t < NT; t++) begin
                int s;
                rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
                s = int'(rng[5:3]);
                if (rng[6]) s = int'(rng[11]);
                set_thr(t, s, rng[7] | rng[8], rng[9] & rng[10], int'(rng[15:12]));
            end
            step(pol == 2'b01 ? "R5 R7 sweep" : "R1 R3 R4 sweep");
        end

        // R9: single-thread build over every status, ready, empty and policy
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 8; s++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int e = 0; e < 2; e++) begin
                        @(negedge clk);
                        s_pol = 2'(p); s_st = 3'(s); s_rdy = 1'(r); s_emp = 1'(e);
                        s_seq = SW'(s * 3 + p);
                        #1;
                        chk("R9 single thread", int'(s_vo), int'(s_to), int'(age_ok(s)), 0);
                    end
                end
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule